// File: doc/BRIEF.md
# Multi-register gated interrupt mask controller

The block gathers a fixed set of level-sensitive interrupt inputs and raises a single interrupt request to the processor. Software reaches three kinds of storage through a simple read/write strobe: a mask word with separate set and clear addresses, a plain enable word, and a priority word divided into equal 4-bit fields. Each source has a fixed vector code, and the block reports the code of the chosen pending source next to a valid flag.

A source is pending only when its input is high and every storage field that governs it enables it. Sources 0 to 7 are governed by the mask bit, the enable bit and a priority field. Sources 8 to 15 are governed by the mask bit and the enable bit only. The processor's current interrupt mask level is an input. At level 15 no vector is offered. At any other level the lowest-numbered pending source wins.

Top module: `intc_mask_ctrl`

## Requirements
- R1: Reset clears the mask, enable and priority storage to zero and holds the level capture registers at zero. After reset irq_o, vector_valid_o and vector_o are 0, and all three words read as zero.
- R2: Source i is pending only when its captured level is 1 and every field that governs it enables it. Sources 0..PRIO_FIELDS-1 need the mask bit, the enable bit and a nonzero priority field. The other sources need only the mask bit and the enable bit.
- R3: A write to the mask set address stores the old mask OR wdata_i[N_SRC-1:0].
- R4: A write to the mask clear address stores the old mask AND NOT wdata_i[N_SRC-1:0].
- R5: A write to the enable address stores wdata_i[N_SRC-1:0] unchanged. A write to the priority address stores all of wdata_i unchanged.
- R6: Source i owns bit N_SRC-1-i of the mask word and of the enable word. Priority field i occupies bits [31-4i:28-4i], and the field enables its source when it is nonzero.
- R7: Address decode compares only addr_i[28:0]. An address that differs only in bits 31..29 reaches the same register.
- R8: irq_o is 1 while at least one source is pending and 0 when none is. It follows a level change or a write one clock after the edge that captures it.
- R9: When imask_i equals 15, vector_valid_o is 0. Otherwise vector_valid_o is 1 whenever a source is pending, and vector_o equals 0x200 + 0x20*i for the lowest pending index i. When vector_valid_o is 0, vector_o is 0.
- R10: Holding a level input at its current value, whether high or low, changes no output.
- R11: With rd_i high, rdata_o returns the stored value at the addressed register (mask at either its set or its clear address, zero-extended). An unmapped address reads as zero, a write to it changes no storage, and rdata_o is 0 while rd_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_lvl_i | input | N_SRC | Level inputs, one per source |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| addr_i | input | ADDR_W | Access address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data |
| imask_i | input | 4 | Processor interrupt mask level |
| irq_o | output | 1 | Interrupt request |
| vector_valid_o | output | 1 | vector_o is meaningful |
| vector_o | output | VEC_W | Vector code of the selected source |

## Verification
A wrong bit in the mask, enable or priority storage shows up in two places: on the next read of that word, and one clock later on irq_o or vector_o once the affected source's level is high. The bench therefore reads each word back after every change and checks the request and vector in the cycle after each write or level edge. Stale level captures and mistakes in bit or field mapping appear as a vector from the wrong source, or as a request that stays high, within one cycle.

// File: rtl/intc_pkg.sv
package intc_pkg;
  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_MSET,
    ACC_MCLR,
    ACC_EN,
    ACC_PRIO
  } acc_e;

  localparam int unsigned DEC_BITS = 29;
  localparam int unsigned IMASK_W  = 4;
endpackage

// File: rtl/intc_decode.sv
module intc_decode
  import intc_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter logic [31:0] MSET_ADDR = 32'h0000_0040,
  parameter logic [31:0] MCLR_ADDR = 32'h0000_0060,
  parameter logic [31:0] EN_ADDR   = 32'h0000_0010,
  parameter logic [31:0] PRIO_ADDR = 32'h0000_0004
) (
  input  logic [ADDR_W-1:0] addr_i,
  output acc_e              acc_o
);
  logic [DEC_BITS-1:0] a_low;
  assign a_low = addr_i[DEC_BITS-1:0];

  always_comb begin
    acc_o = ACC_NONE;
    if (a_low == MSET_ADDR[DEC_BITS-1:0])      acc_o = ACC_MSET;
    else if (a_low == MCLR_ADDR[DEC_BITS-1:0]) acc_o = ACC_MCLR;
    else if (a_low == EN_ADDR[DEC_BITS-1:0])   acc_o = ACC_EN;
    else if (a_low == PRIO_ADDR[DEC_BITS-1:0]) acc_o = ACC_PRIO;
  end
endmodule

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int unsigned N_SRC  = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  acc_e              acc_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [N_SRC-1:0]  mask_o,
  output logic [N_SRC-1:0]  en_o,
  output logic [DATA_W-1:0] prio_o
);
  logic [N_SRC-1:0]  mask_q, en_q;
  logic [DATA_W-1:0] prio_q;
  logic [N_SRC-1:0]  wbits;

  assign wbits = wdata_i[N_SRC-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      en_q   <= '0;
      prio_q <= '0;
    end else if (wr_i) begin
      case (acc_i)
        ACC_MSET: mask_q <= mask_q | wbits;
        ACC_MCLR: mask_q <= mask_q & ~wbits;
        ACC_EN:   en_q   <= wbits;
        ACC_PRIO: prio_q <= wdata_i;
        default:  ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      case (acc_i)
        ACC_MSET, ACC_MCLR: rdata_o = DATA_W'(mask_q);
        ACC_EN:             rdata_o = DATA_W'(en_q);
        ACC_PRIO:           rdata_o = prio_q;
        default:            rdata_o = '0;
      endcase
    end
  end

  assign mask_o = mask_q;
  assign en_o   = en_q;
  assign prio_o = prio_q;
endmodule

// File: rtl/intc_gate.sv
module intc_gate #(
  parameter int unsigned N_SRC   = 16,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned FIELD_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  src_lvl_i,
  input  logic [N_SRC-1:0]  mask_i,
  input  logic [N_SRC-1:0]  en_i,
  input  logic [DATA_W-1:0] prio_i,
  output logic [N_SRC-1:0]  lvl_o,
  output logic [N_SRC-1:0]  pend_o
);
  localparam int unsigned PRIO_FIELDS = DATA_W / FIELD_W;

  logic [N_SRC-1:0] lvl_q;

  // level capture: only a changed input changes state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= '0;
    else if (lvl_q != src_lvl_i) lvl_q <= src_lvl_i;
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    logic mask_ok, en_ok, prio_ok;
    assign mask_ok = mask_i[N_SRC-1-i];
    assign en_ok   = en_i[N_SRC-1-i];
    if (i < PRIO_FIELDS) begin : g_prio
      assign prio_ok = |prio_i[DATA_W-1-i*FIELD_W -: FIELD_W];
    end else begin : g_noprio
      assign prio_ok = 1'b1;
    end
    assign pend_o[i] = lvl_q[i] & mask_ok & en_ok & prio_ok;
  end

  assign lvl_o = lvl_q;
endmodule

// File: rtl/intc_pick.sv
module intc_pick
  import intc_pkg::*;
#(
  parameter int unsigned N_SRC      = 16,
  parameter int unsigned VEC_W      = 12,
  parameter logic [11:0] VEC_BASE   = 12'h200,
  parameter logic [11:0] VEC_STRIDE = 12'h020
) (
  input  logic [N_SRC-1:0]   pend_i,
  input  logic [IMASK_W-1:0] imask_i,
  output logic               irq_o,
  output logic               valid_o,
  output logic [VEC_W-1:0]   vector_o
);
  localparam int unsigned IDX_W = $clog2(N_SRC);
  localparam int unsigned CNT_W = $clog2(N_SRC + 1);

  logic [IDX_W-1:0] idx;
  logic             found;
  logic [CNT_W-1:0] pend_cnt;

  always_comb begin
    idx   = '0;
    found = 1'b0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        idx   = IDX_W'(i);
        found = 1'b1;
      end
    end
  end

  assign pend_cnt = CNT_W'($countones(pend_i));
  assign irq_o    = (pend_cnt != '0);
  assign valid_o  = found && (imask_i != {IMASK_W{1'b1}});
  assign vector_o = valid_o ? (VEC_W'(VEC_BASE) + VEC_W'(idx) * VEC_W'(VEC_STRIDE)) : '0;
endmodule

// File: rtl/intc_mask_ctrl.sv
module intc_mask_ctrl
  import intc_pkg::*;
#(
  parameter int unsigned N_SRC      = 16,
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned FIELD_W    = 4,
  parameter int unsigned VEC_W      = 12,
  parameter logic [11:0] VEC_BASE   = 12'h200,
  parameter logic [11:0] VEC_STRIDE = 12'h020,
  parameter logic [31:0] MSET_ADDR  = 32'h0000_0040,
  parameter logic [31:0] MCLR_ADDR  = 32'h0000_0060,
  parameter logic [31:0] EN_ADDR    = 32'h0000_0010,
  parameter logic [31:0] PRIO_ADDR  = 32'h0000_0004
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  src_lvl_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [3:0]        imask_i,
  output logic              irq_o,
  output logic              vector_valid_o,
  output logic [VEC_W-1:0]  vector_o
);
  acc_e              acc;
  logic [N_SRC-1:0]  mask_q, en_q, lvl_q, pend;
  logic [DATA_W-1:0] prio_q;

  intc_decode #(
    .ADDR_W(ADDR_W), .MSET_ADDR(MSET_ADDR), .MCLR_ADDR(MCLR_ADDR),
    .EN_ADDR(EN_ADDR), .PRIO_ADDR(PRIO_ADDR)
  ) u_dec (
    .addr_i(addr_i),
    .acc_o (acc)
  );

  intc_regs #(.N_SRC(N_SRC), .DATA_W(DATA_W)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_i),
    .rd_i   (rd_i),
    .acc_i  (acc),
    .wdata_i(wdata_i),
    .rdata_o(rdata_o),
    .mask_o (mask_q),
    .en_o   (en_q),
    .prio_o (prio_q)
  );

  intc_gate #(.N_SRC(N_SRC), .DATA_W(DATA_W), .FIELD_W(FIELD_W)) u_gate (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .src_lvl_i(src_lvl_i),
    .mask_i   (mask_q),
    .en_i     (en_q),
    .prio_i   (prio_q),
    .lvl_o    (lvl_q),
    .pend_o   (pend)
  );

  intc_pick #(
    .N_SRC(N_SRC), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
  ) u_pick (
    .pend_i  (pend),
    .imask_i (imask_i),
    .irq_o   (irq_o),
    .valid_o (vector_valid_o),
    .vector_o(vector_o)
  );
endmodule

// File: rtl/intc_mask_ctrl_chk.sv
module intc_mask_ctrl_chk #(
  parameter int unsigned N_SRC     = 16,
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DATA_W    = 32,
  parameter logic [31:0] MSET_ADDR = 32'h0000_0040,
  parameter logic [31:0] MCLR_ADDR = 32'h0000_0060,
  parameter logic [31:0] EN_ADDR   = 32'h0000_0010,
  parameter logic [31:0] PRIO_ADDR = 32'h0000_0004
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_SRC-1:0]  src_lvl_i,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [3:0]        imask_i,
  input logic              irq_o,
  input logic              vector_valid_o,
  input logic [N_SRC-1:0]  mask_q,
  input logic [N_SRC-1:0]  en_q,
  input logic [DATA_W-1:0] prio_q
);
  logic [28:0] a_low;
  logic hit_set, hit_clr, hit_en, hit_prio;
  assign a_low    = addr_i[28:0];
  assign hit_set  = a_low == MSET_ADDR[28:0];
  assign hit_clr  = a_low == MCLR_ADDR[28:0];
  assign hit_en   = a_low == EN_ADDR[28:0];
  assign hit_prio = a_low == PRIO_ADDR[28:0];

  a_r3_set_or: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && hit_set) |=> mask_q == ($past(mask_q) | $past(wdata_i[N_SRC-1:0])));

  a_r4_clr_andnot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && hit_clr) |=> mask_q == ($past(mask_q) & ~$past(wdata_i[N_SRC-1:0])));

  a_r5_en_direct: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && hit_en) |=> en_q == $past(wdata_i[N_SRC-1:0]));

  a_r11_unmapped_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !hit_set && !hit_clr && !hit_en && !hit_prio)
      |=> ($stable(mask_q) && $stable(en_q) && $stable(prio_q)));

  a_r9_imask_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (imask_i == 4'hF) |-> !vector_valid_o);

  a_r8_valid_needs_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vector_valid_o |-> irq_o);

  a_r2_no_level_no_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(src_lvl_i) == '0) |-> !irq_o);
endmodule

bind intc_mask_ctrl intc_mask_ctrl_chk #(
  .N_SRC(N_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MSET_ADDR(MSET_ADDR),
  .MCLR_ADDR(MCLR_ADDR), .EN_ADDR(EN_ADDR), .PRIO_ADDR(PRIO_ADDR)
) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .src_lvl_i     (src_lvl_i),
  .wr_i          (wr_i),
  .addr_i        (addr_i),
  .wdata_i       (wdata_i),
  .imask_i       (imask_i),
  .irq_o         (irq_o),
  .vector_valid_o(vector_valid_o),
  .mask_q        (mask_q),
  .en_q          (en_q),
  .prio_q        (prio_q)
);

// File: tb/intc_mask_ctrl_tb_top.sv
module intc_mask_ctrl_tb_top;
  localparam int N = 16;
  localparam logic [31:0] A_SET  = 32'h40;
  localparam logic [31:0] A_CLR  = 32'h60;
  localparam logic [31:0] A_EN   = 32'h10;
  localparam logic [31:0] A_PRIO = 32'h04;
  localparam logic [31:0] A_NONE = 32'h80;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [N-1:0] src_lvl = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [31:0] addr = '0, wdata = '0;
  logic [31:0] rdata;
  logic [3:0] imask = 4'h0;
  logic irq, vvalid;
  logic [11:0] vec;

  always #5 clk = ~clk;

  intc_mask_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .src_lvl_i(src_lvl), .wr_i(wr), .rd_i(rd),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .imask_i(imask),
    .irq_o(irq), .vector_valid_o(vvalid), .vector_o(vec)
  );

  typedef struct packed {
    logic        is_rd;
    logic        irq;
    logic        vld;
    logic [11:0] vec;
    logic [31:0] rd;
  } exp_t;

  exp_t  exp_q[$];
  string req_q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference model state
  logic [N-1:0]  m_mask = '0, m_en = '0;
  logic [31:0]   m_prio = '0;

  // scoreboard monitor
  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      exp_t  e;
      string r;
      e = exp_q.pop_front();
      r = req_q.pop_front();
      n_chk++;
      if (e.is_rd) begin
        if (rdata !== e.rd) begin
          n_fail++;
          $display("FAIL %s rdata actual=%h expected=%h", r, rdata, e.rd);
        end
      end else if (irq !== e.irq || vvalid !== e.vld || vec !== e.vec) begin
        n_fail++;
        $display("FAIL %s irq/valid/vec actual=%b/%b/%h expected=%b/%b/%h",
                 r, irq, vvalid, vec, e.irq, e.vld, e.vec);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic logic pend_m(int i);
    logic p;
    p = src_lvl[i] & m_mask[N-1-i] & m_en[N-1-i];
    if (i < 8) p = p & (m_prio[31-4*i -: 4] != 4'h0);
    return p;
  endfunction

  task automatic push_out(string r);
    exp_t e;
    e = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_m(i)) begin
        e.irq = 1'b1;
        e.vec = 12'h200 + 12'(i) * 12'h020;
      end
    end
    e.vld = e.irq && (imask != 4'hF);
    if (!e.vld) e.vec = '0;
    exp_q.push_back(e);
    req_q.push_back(r);
  endtask

  task automatic do_write(logic [31:0] a, logic [31:0] d);
    logic [28:0] lo;
    tick();
    wr = 1'b1; addr = a; wdata = d;
    tick();
    wr = 1'b0;
    lo = a[28:0];
    if (lo == A_SET[28:0])       m_mask = m_mask | d[N-1:0];
    else if (lo == A_CLR[28:0])  m_mask = m_mask & ~d[N-1:0];
    else if (lo == A_EN[28:0])   m_en   = d[N-1:0];
    else if (lo == A_PRIO[28:0]) m_prio = d;
  endtask

  task automatic set_lvl(logic [N-1:0] v);
    tick();
    src_lvl = v;
    tick();
  endtask

  task automatic check_rd(logic [31:0] a, logic [31:0] val, logic strobe, string r);
    exp_t e;
    tick();
    rd = strobe; addr = a;
    e = '0; e.is_rd = 1'b1; e.rd = val;
    exp_q.push_back(e);
    req_q.push_back(r);
    tick();
    rd = 1'b0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    // R1 reset state
    tick(); push_out("R1");
    check_rd(A_SET, 32'h0, 1'b1, "R1");
    check_rd(A_EN, 32'h0, 1'b1, "R1");
    check_rd(A_PRIO, 32'h0, 1'b1, "R1");
    // R2 all levels high, nothing enabled
    set_lvl('1); push_out("R2");
    // R5 enable direct
    do_write(A_EN, 32'h0000_FFFF); push_out("R2");
    check_rd(A_EN, 32'h0000_FFFF, 1'b1, "R5");
    // R6 sources 8..15 own mask bits 7..0
    do_write(A_SET, 32'h0000_00FF); push_out("R6");
    // R2 source 0 mask set but priority field zero
    do_write(A_SET, 32'h0000_8000); push_out("R2");
    check_rd(A_CLR, 32'h0000_80FF, 1'b1, "R3");
    // R5 R6 top priority field enables source 0
    do_write(A_PRIO, 32'hF000_0000); push_out("R6");
    check_rd(A_PRIO, 32'hF000_0000, 1'b1, "R5");
    // R9 imask level 15 blocks vector
    tick(); imask = 4'hF; push_out("R9");
    tick(); imask = 4'hE; push_out("R9");
    // R4 clear source 0 and 15
    do_write(A_CLR, 32'h0000_8001); push_out("R4");
    check_rd(A_SET, 32'h0000_00FE, 1'b1, "R4");
    // R7 aliased clear address, R8 request falls
    do_write(A_CLR | 32'hE000_0000, 32'h0000_00FE); push_out("R8");
    check_rd(A_SET | 32'hA000_0000, 32'h0, 1'b1, "R7");
    // R11 unmapped access
    do_write(A_NONE, 32'hFFFF_FFFF); push_out("R11");
    check_rd(A_NONE, 32'h0, 1'b1, "R11");
    check_rd(A_EN, 32'h0000_FFFF, 1'b1, "R11");
    check_rd(A_EN, 32'h0, 1'b0, "R11");
    // R8 single source 15
    do_write(A_SET, 32'h0000_0001); push_out("R8");
    // R10 hold level high
    set_lvl(src_lvl); push_out("R10");
    // R8 drop source 15
    set_lvl(16'h7FFF); push_out("R8");
    // R10 hold level low
    set_lvl(16'h7FFF); push_out("R10");
    // R2 second priority field governs source 1
    do_write(A_SET, 32'h0000_4000);
    do_write(A_PRIO, 32'h0300_0000); push_out("R2");
    repeat (3) tick();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule